// File: doc/BRIEF.md
# Masked Multi-Pin Output Compare Unit

This block is one output-compare channel of a timer. A free-running counter advances on every clock for which the count enable input is high. When the counter equals a programmed compare value, the channel performs its action: each of five port pins whose enable bit is set in a mask register is loaded with the matching bit of a data register. A single compare event can therefore set, clear or mix a pattern across several pins in the same cycle. Pins whose mask bit is clear keep their value.

Software programs the channel through a small byte-wide register bus. There is one byte for each half of the compare value, one byte for the pin mask, one byte for the pin data, and one write-only force register. Writing the force bit runs the same masked pin action immediately, without waiting for the counter. A match flag output is high during the cycle in which a real compare hit occurs. An interrupt controller or a status register can use that flag.

Top module: `mpoc_unit`

## Requirements
- R1: While reset is asserted and after it is released, the pins, the match flag, the mask, the data and the compare value are all zero, and the counter starts from 0.
- R2: The counter adds one on each clock edge where `cnt_en` is high, holds where it is low, and wraps from 0xFFFF to 0x0000.
- R3: `match_flag` is high in exactly those cycles in which `cnt_en` is high and the counter equals the compare value. A counter that is stopped on the compare value raises no flag.
- R4: A match updates the pins on the clock edge that ends the matching cycle. Pin k, where `pin_out[k]` stands for register bit k+3, takes data bit k+3 when mask bit k+3 is 1, and keeps its value otherwise.
- R5: The mask register is at address 2 and the data register at address 3. Only bits 7..3 are stored in each. Bits 2..0 read as 0, and writing them has no effect.
- R6: Writing address 4 with bit 7 set runs the masked pin action on that write's clock edge and leaves `match_flag` low. Writing address 4 with bit 7 clear does nothing. Address 4 always reads 0.
- R7: When a real match and a force fall in the same cycle, the pins are updated once, with the mask and data as they stood before that edge.
- R8: A mask or data write in the cycle of a match takes effect only after that edge. The match action uses the values held before the write.
- R9: The compare value is written and read as a high byte at address 0 and a low byte at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| pin_out | output | 5 | Driven port pins; bit 0 corresponds to register bit 3 |
| match_flag | output | 1 | High during a cycle with a real compare hit |

## Verification
The bench uses a mask that leaves some pins uncovered, to catch a design that writes every pin on a match rather than only the masked ones. It stops the counter on the compare value to catch a flag that ignores the enable. It also runs the counter through a full wrap to find the single later hit, which a wrong width or a missed rollover would shift or lose. In one test a mask write shares a cycle with a hit, and in another a force shares a cycle with a hit: a design that forwards the new mask, or that raises the flag on a force, shows a different pin pattern or flag value. A force write with bit 7 clear must leave the pins alone, and the unused low bits must read back as zero.

// File: rtl/mpoc_pkg.sv
package mpoc_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int FORCE_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CMP_HI = 3'd0,
    A_CMP_LO = 3'd1,
    A_MASK   = 3'd2,
    A_DATA   = 3'd3,
    A_FORCE  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/mpoc_rst_sync.sv
module mpoc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/mpoc_timer.sv
module mpoc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign hit = en && (cnt_q == cmp);
endmodule

// File: rtl/mpoc_regs.sv
module mpoc_regs import mpoc_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int PIN_W   = 5,
  parameter int PIN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cmp,
  output logic [PIN_W-1:0]  mask,
  output logic [PIN_W-1:0]  data,
  output logic              fire
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [PIN_W-1:0] mask_q, mask_d, data_q, data_d;

  always_comb begin
    cmp_d  = cmp_q;
    mask_d = mask_q;
    data_d = data_q;
    fire   = 1'b0;
    if (we) begin
      case (addr)
        A_CMP_HI: cmp_d[CNT_W-1 -: DATA_W] = wdata;
        A_CMP_LO: cmp_d[DATA_W-1:0]        = wdata;
        A_MASK:   mask_d = wdata[PIN_LSB +: PIN_W];
        A_DATA:   data_d = wdata[PIN_LSB +: PIN_W];
        A_FORCE:  fire   = wdata[FORCE_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      cmp_q  <= cmp_d;
      mask_q <= mask_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMP_HI: rdata = cmp_q[CNT_W-1 -: DATA_W];
      A_CMP_LO: rdata = cmp_q[DATA_W-1:0];
      A_MASK:   rdata[PIN_LSB +: PIN_W] = mask_q;
      A_DATA:   rdata[PIN_LSB +: PIN_W] = data_q;
      default:  rdata = '0;
    endcase
  end

  assign cmp  = cmp_q;
  assign mask = mask_q;
  assign data = data_q;
endmodule

// File: rtl/mpoc_port.sv
module mpoc_port #(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic [PIN_W-1:0] mask,
  input  logic [PIN_W-1:0] data,
  output logic [PIN_W-1:0] pins
);
  logic [PIN_W-1:0] pin_q, pin_d;

  for (genvar g = 0; g < PIN_W; g++) begin : g_pin
    always_comb begin
      pin_d[g] = pin_q[g];
      if (act && mask[g]) pin_d[g] = data[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pins = pin_q;
endmodule

// File: rtl/mpoc_unit.sv
module mpoc_unit import mpoc_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int PIN_W   = 5,
  parameter int PIN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PIN_W-1:0]  pin_out,
  output logic              match_flag
);
  logic             rst_s;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [PIN_W-1:0] mask_q, data_q;
  logic             hit, fire;

  mpoc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  mpoc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s), .en(cnt_en), .cmp(cmp_q),
    .cnt(cnt_q), .hit(hit)
  );

  mpoc_regs #(.CNT_W(CNT_W), .PIN_W(PIN_W), .PIN_LSB(PIN_LSB)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cmp(cmp_q),
    .mask(mask_q), .data(data_q), .fire(fire)
  );

  mpoc_port #(.PIN_W(PIN_W)) u_port (
    .clk(clk), .rst_n(rst_s), .act(hit | fire),
    .mask(mask_q), .data(data_q), .pins(pin_out)
  );

  assign match_flag = hit;
endmodule

// File: rtl/mpoc_chk.sv
module mpoc_chk import mpoc_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PIN_W = 5
) (
  input logic              clk,
  input logic              rst_s,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              hit,
  input logic              fire,
  input logic [PIN_W-1:0]  mask_q,
  input logic [PIN_W-1:0]  pin_out,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              match_flag
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cnt_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !cnt_en |=> $stable(cnt_q));

  // R3
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_s)
    match_flag |-> cnt_en);

  // R4
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> ((pin_out ^ $past(pin_out)) & ~$past(mask_q)) == '0);

  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(hit || fire) |=> $stable(pin_out));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == A_MASK || bus_addr == A_DATA) |-> bus_rdata[2:0] == 3'b000);

  // R6
  force_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == A_FORCE) |-> bus_rdata == '0);
endmodule

bind mpoc_unit mpoc_chk #(.CNT_W(CNT_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .cnt_en(cnt_en), .cnt_q(cnt_q), .hit(hit),
  .fire(fire), .mask_q(mask_q), .pin_out(pin_out), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .match_flag(match_flag)
);

// File: tb/sim_mpoc_unit.sv
module sim_mpoc_unit;
  logic       clk = 1'b0;
  logic       rst_n, cnt_en, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [4:0] pin_out;
  logic       match_flag;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  mpoc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .match_flag(match_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0; cnt_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", pin_out, 5'h00);
    chk("R1 flag in reset", match_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd2, v); chk("R1 mask after reset", v, 8'h00);
    rd(3'd3, v); chk("R1 data after reset", v, 8'h00);
    rd(3'd0, v); chk("R1 cmp hi after reset", v, 8'h00);
    chk("R1 pins after reset", pin_out, 5'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R5 mask low bits", v, 8'hF8);
    wr(3'd3, 8'hAF); rd(3'd3, v); chk("R5 data low bits", v, 8'hA8);
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rd(3'd0, v); chk("R9 cmp hi", v, 8'h12);
    rd(3'd1, v); chk("R9 cmp lo", v, 8'h34);
    rd(3'd4, v); chk("R6 force reads 0", v, 8'h00);
    chk("R1 pins untouched by setup", pin_out, 5'h00);
  endtask

  // counter is 0 here; match at 8 drives pins 4,2,0 high
  task automatic t_match();
    wr(3'd0, 8'h00); wr(3'd1, 8'h08);
    wr(3'd2, 8'hA8); wr(3'd3, 8'hF8);
    @(negedge clk);
    cnt_en = 1'b1;
    #1;
    chk("R3 flag at count 0", match_flag, 1'b0);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk); #1;
      chk($sformatf("R3 flag at count %0d", i), match_flag, i == 8);
      chk($sformatf("R4 pins at count %0d", i), pin_out, (i >= 9) ? 5'h15 : 5'h00);
    end
    cnt_en = 1'b0;
  endtask

  // counter is 12: stopped on compare -> no flag; then one enabled cycle
  task automatic t_hold();
    wr(3'd1, 8'h0C);
    wr(3'd2, 8'h80); wr(3'd3, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R3 no flag while stopped", match_flag, 1'b0);
      chk("R2 pins hold while stopped", pin_out, 5'h15);
    end
    @(negedge clk);
    cnt_en = 1'b1;
    #1 chk("R3 flag when enabled on compare", match_flag, 1'b1);
    @(negedge clk);
    cnt_en = 1'b0;
    #1 chk("R4 only masked pin 4 cleared", pin_out, 5'h05);
    chk("R2 counter moved past compare", match_flag, 1'b0);
  endtask

  // counter is 13, compare 12
  task automatic t_force();
    logic [7:0] v;
    wr(3'd2, 8'h18); wr(3'd3, 8'h10);
    wr(3'd4, 8'h7F);
    #1 chk("R6 force bit clear has no effect", pin_out, 5'h05);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h80;
    #1 chk("R6 no flag on force", match_flag, 1'b0);
    @(negedge clk);
    bus_we = 1'b0;
    #1 chk("R6 forced pins", pin_out, 5'h06);
    rd(3'd4, v); chk("R6 force reads 0 after use", v, 8'h00);
  endtask

  // counter is 13
  task automatic t_same();
    logic [7:0] v;
    wr(3'd1, 8'h0D); wr(3'd3, 8'h08);
    @(negedge clk);
    cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'hF8;
    #1 chk("R8 flag during mask write", match_flag, 1'b1);
    @(negedge clk);
    cnt_en = 1'b0; bus_we = 1'b0;
    #1 chk("R8 match used old mask", pin_out, 5'h05);
    rd(3'd2, v); chk("R8 new mask stored", v, 8'hF8);
    wr(3'd1, 8'h0E); wr(3'd3, 8'h00);
    @(negedge clk);
    cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h80;
    #1 chk("R7 flag with force", match_flag, 1'b1);
    @(negedge clk);
    cnt_en = 1'b0; bus_we = 1'b0;
    #1 chk("R7 single update", pin_out, 5'h00);
    chk("R7 flag gone", match_flag, 1'b0);
  endtask

  // counter is 15; next hit at 3 only after wrapping
  task automatic t_wrap();
    int seen = 0;
    int first = -1;
    wr(3'd1, 8'h03); wr(3'd2, 8'h08); wr(3'd3, 8'h08);
    @(negedge clk);
    cnt_en = 1'b1;
    for (int k = 0; k <= 65526; k++) begin
      #1;
      if (match_flag) begin
        seen++;
        if (first < 0) first = k;
      end
      @(negedge clk);
    end
    cnt_en = 1'b0;
    #1;
    chk("R2 one hit across wrap", seen, 1);
    chk("R2 hit step after wrap", first, 65524);
    chk("R4 pin 0 set after wrap", pin_out, 5'h01);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_match();
    t_hold();
    t_force();
    t_same();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule